// File: doc/BRIEF.md
# Masked Wake Source Aggregator

This block folds eighteen wake request lines into a single wake event for the power sequencer. It also keeps a status vector that shows which requests are pending. Fifteen sources arrive as plain request lines. The low-power timer request arrives on its own pin. Two more sources are made inside the block from 45 general-purpose I/O lines: an AND group and an OR group, each over its own selectable set of lines.

Every input first passes through a two-flop synchronizer. The pending vector is registered. A per-source enable bit decides whether a pending source may raise the wake event. A per-source type bit chooses slow (precise) or fast wake, and the block forwards one combined type to the sequencer. Timer and watchdog requests are sticky and are cleared by writing ones to a clear register. All other sources follow their synchronized level.

A small register port holds the masks. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `wake_agg`

## Requirements
- R1: Status bit layout: bit 0 is the timer, bit 1 the GPIO AND group, bit 2 the GPIO OR group, and bits 3..17 follow `ext_req_i[0..14]`. Here bits 3..10 are doorbells 0..7, then the host IRQ, radio IRQ, RTC, debug power-up, debug force-active and secure error, and bit 17 is the core watchdog. A level source appears in status three clock edges after it changes at the input.
- R2: The enable register (address 0) resets to zero. `wake_o` is high exactly when some status bit is pending and its enable bit is 1.
- R3: After reset the AND masks and OR masks select every GPIO. Addresses 2/3 hold the AND mask for GPIO 31..0 and 44..32 (bits 12:0). Addresses 4/5 hold the OR mask the same way. Reads of address 3 or 5 return 0x1FFF after reset.
- R4: The AND group is pending only when every selected GPIO is high. It stays low when no GPIO is selected.
- R5: The OR group is pending when any selected GPIO is high.
- R6: The type register (address 1, 1 = fast) resets to zero. `wake_fast_o` is high only when `wake_o` is high and every pending enabled source has type 1.
- R7: The timer request is sticky. It stays pending after its input falls, and it is cleared by writing 1 to bit 0 of address 6. The write takes effect on that edge.
- R8: The watchdog request (bit 17) is sticky and is cleared by writing 1 to bit 1 of address 6. A clear in a cycle where the synchronized request is still high leaves it pending. A timer clear does not touch it.
- R9: Reading address 7 returns the status vector. With nothing pending, status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_i | input | 45 | Raw GPIO levels |
| tmr_req_i | input | 1 | Low-power timer wake request |
| ext_req_i | input | 15 | Request lines for status bits 3..17 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| status_o | output | 18 | Pending request vector |
| wake_o | output | 1 | Combined wake event |
| wake_fast_o | output | 1 | Combined wake type, 1 = fast |

## Verification
Two functions can act on a sticky request in the same cycle: a write-one-to-clear and a new or still-asserted request. The bench holds the watchdog line high while it writes the clear bit. It then reads status at the port and expects the bit to remain pending. After the line has fallen, a second clear must empty the bit. The type-combining logic is also judged with fast and slow sources pending at the same time. A single slow source must pull the type to slow.

// File: rtl/wake_agg.sv
module wake_agg #(
  parameter int NGPIO = 45,
  parameter int DW    = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGPIO-1:0] gpio_i,
  input  logic             tmr_req_i,
  input  logic [14:0]      ext_req_i,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [17:0]      status_o,
  output logic             wake_o,
  output logic             wake_fast_o
);
  localparam int NSRC = 18;
  localparam int GHI  = NGPIO - DW;
  localparam int WDT  = NSRC - 1;

  logic [NGPIO-1:0] g1, g2, amask, omask;
  logic [15:0]      s1, s2;
  logic [NSRC-1:0]  en_q, type_q, pend;
  logic             and_hit, or_hit, clr_t, clr_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      g1 <= '0; g2 <= '0; s1 <= '0; s2 <= '0;
    end else begin
      g1 <= gpio_i;                g2 <= g1;
      s1 <= {ext_req_i, tmr_req_i}; s2 <= s1;
    end

  assign and_hit = (|amask) & (&(g2 | ~amask));
  assign or_hit  = |(g2 & omask);
  assign clr_t   = reg_we && reg_addr == AW'(6) && reg_wdata[0];
  assign clr_w   = reg_we && reg_addr == AW'(6) && reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= '0;
      type_q <= '0;
      amask  <= '1;
      omask  <= '1;
    end else if (reg_we) begin
      case (reg_addr)
        AW'(0): en_q   <= reg_wdata[NSRC-1:0];
        AW'(1): type_q <= reg_wdata[NSRC-1:0];
        AW'(2): amask[DW-1:0]     <= reg_wdata;
        AW'(3): amask[NGPIO-1:DW] <= reg_wdata[GHI-1:0];
        AW'(4): omask[DW-1:0]     <= reg_wdata;
        AW'(5): omask[NGPIO-1:DW] <= reg_wdata[GHI-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else begin
      pend[0]          <= (pend[0] & ~clr_t) | s2[0];
      pend[1]          <= and_hit;
      pend[2]          <= or_hit;
      pend[WDT-1:3]    <= s2[14:1];
      pend[WDT]        <= (pend[WDT] & ~clr_w) | s2[15];
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata[NSRC-1:0] = en_q;
      AW'(1): reg_rdata[NSRC-1:0] = type_q;
      AW'(2): reg_rdata           = amask[DW-1:0];
      AW'(3): reg_rdata[GHI-1:0]  = amask[NGPIO-1:DW];
      AW'(4): reg_rdata           = omask[DW-1:0];
      AW'(5): reg_rdata[GHI-1:0]  = omask[NGPIO-1:DW];
      AW'(7): reg_rdata[NSRC-1:0] = pend;
      default: ;
    endcase
  end

  assign status_o    = pend;
  assign wake_o      = |(pend & en_q);
  assign wake_fast_o = wake_o & (&(~(pend & en_q) | type_q));

  // R7: timer request holds until cleared
  a_r7_timer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !clr_t) |=> status_o[0]);
  // R8: watchdog request holds until cleared
  a_r8_wdt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[WDT] && !clr_w) |=> status_o[WDT]);
  // R4: empty AND selection never pends
  a_r4_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (amask == '0) |=> !status_o[1]);
  // R5: a selected high GPIO makes the OR group pend
  a_r5_or_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (|(g2 & omask)) |=> status_o[2]);
  // R6: fast type only with a wake event
  a_r6_fast_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fast_o |-> wake_o);
  // R2/R3: reset state of masks on release
  a_r3_reset_masks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && amask == '1 && omask == '1));
endmodule

// File: tb/test_wake_agg.sv
module test_wake_agg;
  logic        clk = 0, rst_n = 0;
  logic [44:0] gpio_i = '0;
  logic        tmr_req_i = 0;
  logic [14:0] ext_req_i = '0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [17:0] status_o;
  logic        wake_o, wake_fast_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  wake_agg i_wake_agg (.clk, .rst_n, .gpio_i, .tmr_req_i, .ext_req_i, .reg_we,
    .reg_addr, .reg_wdata, .reg_rdata, .status_o, .wake_o, .wake_fast_o);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 status at reset", 32'(status_o), 0);
    chk("R2 wake at reset", 32'(wake_o), 0);
    rd(0, d); chk("R2 enable reset", d, 0);
    rd(1, d); chk("R6 type reset", d, 0);
    rd(2, d); chk("R3 and mask lo", d, 32'hFFFF_FFFF);
    rd(5, d); chk("R3 or mask hi", d, 32'h1FFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); ext_req_i[0] = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 latency not yet", 32'(status_o[3]), 0);
    @(negedge clk);
    chk("R1 doorbell0 at bit 3", 32'(status_o), 32'h8);
    chk("R2 masked source no wake", 32'(wake_o), 0);
    wr(0, 32'h8);
    chk("R2 enabled wake", 32'(wake_o), 1);
    chk("R6 slow type", 32'(wake_fast_o), 0);
    wr(1, 32'h8);
    chk("R6 all fast", 32'(wake_fast_o), 1);
    ext_req_i[10] = 1; wr(0, 32'h2008); settle();
    chk("R6 one slow pulls slow", 32'(wake_fast_o), 0);
    rd(7, d); chk("R9 read status", d, 32'h2008);
    ext_req_i = '0; settle();
    chk("R9 status clear", 32'(status_o), 0);
    chk("R2 wake clear", 32'(wake_o), 0);
    wr(0, 0); wr(1, 0);
  endtask

  task automatic t_and();
    settle();
    chk("R4 all low", 32'(status_o[1]), 0);
    chk("R5 all low", 32'(status_o[2]), 0);
    gpio_i = '1; settle();
    chk("R4 all high", 32'(status_o[1]), 1);
    chk("R5 all high", 32'(status_o[2]), 1);
    wr(2, 32'h8); wr(3, 32'h100);
    gpio_i = '0; gpio_i[3] = 1; gpio_i[40] = 1; settle();
    chk("R4 selected all high", 32'(status_o[1]), 1);
    gpio_i[40] = 0; settle();
    chk("R4 one selected low", 32'(status_o[1]), 0);
    wr(2, 0); wr(3, 0); gpio_i = '1; settle();
    chk("R4 empty selection", 32'(status_o[1]), 0);
    gpio_i = '0;
  endtask

  task automatic t_or();
    wr(4, 0); wr(5, 32'h1000);
    gpio_i[44] = 1; settle();
    chk("R5 gpio44 selected", 32'(status_o[2]), 1);
    gpio_i = '1; gpio_i[44] = 0; settle();
    chk("R5 unselected high", 32'(status_o[2]), 0);
    gpio_i = '0;
  endtask

  task automatic t_timer();
    @(negedge clk); tmr_req_i = 1;
    @(negedge clk); tmr_req_i = 0;
    settle();
    chk("R7 timer sticky", 32'(status_o[0]), 1);
    wr(6, 32'h1);
    chk("R7 timer cleared", 32'(status_o[0]), 0);
  endtask

  task automatic t_wdt();
    @(negedge clk); ext_req_i[14] = 1; settle();
    chk("R8 watchdog at bit 17", 32'(status_o), 32'h20000);
    wr(6, 32'h2);
    chk("R8 clear while high", 32'(status_o[17]), 1);
    ext_req_i[14] = 0; settle();
    chk("R8 sticky after fall", 32'(status_o[17]), 1);
    wr(6, 32'h1);
    chk("R8 timer clear ignored", 32'(status_o[17]), 1);
    wr(6, 32'h2);
    chk("R8 watchdog cleared", 32'(status_o[17]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_level(); t_and(); t_or(); t_timer(); t_wdt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule